// File: doc/BRIEF.md
# Double-Width Funnel Shifter

This unit joins a destination word and a source word into one double-width value, shifts it left or right by a count taken from an instruction, and returns one destination-width result word together with an updated status-flag set. The left direction moves source bits into the destination from the bottom. The right direction moves source bits into the destination from the top. Counts larger than the word width are handled the way a common desktop processor family handles them: the destination wraps back in behind the source.

The arithmetic and flag logic is combinational. The unit registers its outputs once, so it fits as a single execute stage behind an operand-read stage. Operand fetch, instruction decode and any memory read-modify-write are left to the surrounding pipeline. The write-enable output tells that pipeline whether the result and flags are to be committed. When the effective count is zero, nothing is to be committed: the destination and the incoming flags are passed through unchanged.

Top module: `fsh_unit`

## Requirements
- R1: The effective count is `cnt_i[4:0]` (0 to 31). Bits 7:5 of `cnt_i` have no effect on any output.
- R2: With `dir_right_i` = 0 (left), the result is the upper 16 bits of {dst, src} shifted left by the effective count c. When c > 16, dst shifted left by (c−16) is also ORed into the 32-bit shifted value before the upper half is taken.
- R3: With `dir_right_i` = 1 (right), the result is the lower 16 bits of {src, dst} shifted right by c. When c > 16, dst shifted left by (32−c) is also ORed into the 32-bit shifted value.
- R4: On a left shift with c ≠ 0, CF is bit (32−c) of {dst, src}, and OF is CF XOR result bit 15.
- R5: On a right shift with c ≠ 0, CF is bit (c−1) of dst, and it is 0 when c−1 ≥ 16. OF is result bit 15 XOR result bit 14.
- R6: For c ≠ 0: SF is result bit 15; ZF is 1 when the result is zero; PF is 1 when the low 8 result bits hold an even number of ones; AF is 0. The flag vector layout, for input and output alike, is bit 0 CF, bit 1 PF, bit 2 AF, bit 3 ZF, bit 4 SF, bit 5 OF.
- R7: For c = 0, the result equals dst, the output flags equal `flags_i`, and `wr_en_o` is 0. For c ≠ 0, `wr_en_o` is 1.
- R8: All outputs are registered. They reflect the inputs present at the previous rising clock edge. A synchronous active-high reset clears the result, the flags and the write-enable to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dst_i | input | 16 | Destination operand |
| src_i | input | 16 | Source operand supplying the shifted-in bits |
| cnt_i | input | 8 | Shift count, only the low 5 bits used |
| dir_right_i | input | 1 | 0 = left funnel shift, 1 = right funnel shift |
| flags_i | input | 6 | Incoming flags {OF,SF,ZF,AF,PF,CF} |
| result_o | output | 16 | Shifted result word |
| flags_o | output | 6 | Updated flags {OF,SF,ZF,AF,PF,CF} |
| wr_en_o | output | 1 | Result and flags are to be committed |

## Verification
Every output is due exactly one rising edge after its stimulus is applied, because the only register between the inputs and the outputs is the output stage. The bench applies each operand set on a falling edge and compares result, flags and write-enable at the next falling edge. Each comparison therefore reads the values captured from the vector just applied, never an older or a newer one. The sweep covers all 256 count codes in both directions, so every effective count from 0 to 31 is reached several times, with differing upper count bits each time.

// File: rtl/fsh_pkg.sv
package fsh_pkg;

    typedef enum logic {
        DIR_LEFT  = 1'b0,
        DIR_RIGHT = 1'b1
    } fsh_dir_e;

    // bit 5 .. bit 0
    typedef struct packed {
        logic ovf;
        logic sgn;
        logic zro;
        logic aux;
        logic par;
        logic cry;
    } fsh_flags_t;

    localparam int FLAG_W = $bits(fsh_flags_t);

    // 1 when the byte holds an even number of ones
    function automatic logic even_parity8(input logic [7:0] b);
        return ~^b;
    endfunction

endpackage

// File: rtl/fsh_count_mask.sv
module fsh_count_mask #(
    parameter int CNT_W = 8,
    parameter int CW    = 5
) (
    input  logic [CNT_W-1:0] cnt_i,
    output logic [CW-1:0]    eff_o,
    output logic             zero_o
);

    assign eff_o  = cnt_i[CW-1:0];
    assign zero_o = (cnt_i[CW-1:0] == '0);

    generate
        if (CNT_W > CW) begin : g_hi
            logic unused_cnt_hi;
            assign unused_cnt_hi = ^cnt_i[CNT_W-1:CW];
        end
    endgenerate

endmodule

// File: rtl/fsh_datapath.sv
module fsh_datapath
    import fsh_pkg::*;
#(
    parameter int W  = 16,
    parameter int CW = $clog2(2*W)
) (
    input  logic [W-1:0]  dst_i,
    input  logic [W-1:0]  src_i,
    input  logic [CW-1:0] cnt_i,
    input  fsh_dir_e      dir_i,
    output logic [W-1:0]  res_o,
    output logic          cry_o
);

    localparam int DW = 2 * W;

    logic [DW-1:0] cat_l, cat_r;
    logic [DW-1:0] sh_l, sh_r;
    logic [DW-1:0] dst_wide;
    logic [DW-1:0] cry_vec_l, cry_vec_r;
    int            c;

    assign c        = int'(cnt_i);
    assign cat_l    = {dst_i, src_i};
    assign cat_r    = {src_i, dst_i};
    assign dst_wide = {{W{1'b0}}, dst_i};

    // left: destination high, source low
    always_comb begin
        sh_l = cat_l << cnt_i;
        if (c > W) begin
            sh_l = sh_l | (dst_wide << (c - W));
        end
    end

    // right: source high, destination low
    always_comb begin
        sh_r = cat_r >> cnt_i;
        if (c > W) begin
            sh_r = sh_r | (dst_wide << (DW - c));
        end
    end

    // last bit pushed out of the destination
    always_comb begin
        cry_vec_l = '0;
        cry_vec_r = '0;
        if (c != 0) begin
            cry_vec_l = cat_l >> (DW - c);
            cry_vec_r = dst_wide >> (c - 1);
        end
    end

    always_comb begin
        if (dir_i == DIR_RIGHT) begin
            res_o = sh_r[W-1:0];
            cry_o = cry_vec_r[0];
        end else begin
            res_o = sh_l[DW-1:W];
            cry_o = cry_vec_l[0];
        end
    end

endmodule

// File: rtl/fsh_flag_gen.sv
module fsh_flag_gen
    import fsh_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] res_i,
    input  logic         cry_i,
    input  fsh_dir_e     dir_i,
    input  logic         zero_cnt_i,
    input  fsh_flags_t   flags_i,
    output fsh_flags_t   flags_o,
    output logic         wr_en_o
);

    fsh_flags_t calc;

    always_comb begin
        calc.cry = cry_i;
        calc.par = even_parity8(res_i[7:0]);
        calc.aux = 1'b0;
        calc.zro = (res_i == '0);
        calc.sgn = res_i[W-1];
        if (dir_i == DIR_RIGHT) begin
            calc.ovf = res_i[W-1] ^ res_i[W-2];
        end else begin
            calc.ovf = cry_i ^ res_i[W-1];
        end
    end

    assign flags_o = zero_cnt_i ? flags_i : calc;
    assign wr_en_o = ~zero_cnt_i;

endmodule

// File: rtl/fsh_unit.sv
module fsh_unit
    import fsh_pkg::*;
#(
    parameter int W     = 16,
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [W-1:0]      dst_i,
    input  logic [W-1:0]      src_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              dir_right_i,
    input  logic [FLAG_W-1:0] flags_i,
    output logic [W-1:0]      result_o,
    output logic [FLAG_W-1:0] flags_o,
    output logic              wr_en_o
);

    localparam int CW = $clog2(2*W);

    logic [CW-1:0] eff_cnt;
    logic          zero_cnt;
    logic [W-1:0]  dp_res;
    logic          dp_cry;
    logic [W-1:0]  nxt_res;
    fsh_flags_t    nxt_flags;
    logic          nxt_we;
    fsh_dir_e      dir;

    logic [W-1:0]  result_q;
    fsh_flags_t    flags_q;
    logic          wr_en_q;
    logic          primed_q;

    assign dir = dir_right_i ? DIR_RIGHT : DIR_LEFT;

    fsh_count_mask #(.CNT_W(CNT_W), .CW(CW)) u_mask (
        .cnt_i  (cnt_i),
        .eff_o  (eff_cnt),
        .zero_o (zero_cnt)
    );

    fsh_datapath #(.W(W), .CW(CW)) u_dp (
        .dst_i (dst_i),
        .src_i (src_i),
        .cnt_i (eff_cnt),
        .dir_i (dir),
        .res_o (dp_res),
        .cry_o (dp_cry)
    );

    fsh_flag_gen #(.W(W)) u_flags (
        .res_i      (dp_res),
        .cry_i      (dp_cry),
        .dir_i      (dir),
        .zero_cnt_i (zero_cnt),
        .flags_i    (fsh_flags_t'(flags_i)),
        .flags_o    (nxt_flags),
        .wr_en_o    (nxt_we)
    );

    assign nxt_res = zero_cnt ? dst_i : dp_res;

    always_ff @(posedge clk) begin
        if (rst) begin
            result_q <= '0;
            flags_q  <= '0;
            wr_en_q  <= 1'b0;
            primed_q <= 1'b0;
        end else begin
            result_q <= nxt_res;
            flags_q  <= nxt_flags;
            wr_en_q  <= nxt_we;
            primed_q <= 1'b1;
        end
    end

    assign result_o = result_q;
    assign flags_o  = flags_q;
    assign wr_en_o  = wr_en_q;

    // R1: upper count bits never suppress a commit
    a_r1_count_mask: assert property (@(posedge clk) disable iff (rst)
        (primed_q && $past(cnt_i[CW-1:0]) != '0) |-> wr_en_q);

    // R7: zero count passes everything through
    a_r7_zero_hold: assert property (@(posedge clk) disable iff (rst)
        (primed_q && $past(cnt_i[CW-1:0]) == '0) |->
        (result_q == $past(dst_i) && flags_q == $past(flags_i) && !wr_en_q));

    // R6
    a_r6_aux_clear: assert property (@(posedge clk) disable iff (rst)
        wr_en_q |-> !flags_q.aux);

    // R6
    a_r6_sign_zero: assert property (@(posedge clk) disable iff (rst)
        wr_en_q |-> (flags_q.sgn == result_q[W-1] && flags_q.zro == (result_q == '0)));

    // R4
    a_r4_left_ovf: assert property (@(posedge clk) disable iff (rst)
        (primed_q && wr_en_q && !$past(dir_right_i)) |->
        (flags_q.ovf == (flags_q.cry ^ result_q[W-1])));

    // R5
    a_r5_right_ovf: assert property (@(posedge clk) disable iff (rst)
        (primed_q && wr_en_q && $past(dir_right_i)) |->
        (flags_q.ovf == (result_q[W-1] ^ result_q[W-2])));

endmodule

// File: tb/tb_fsh_unit.sv
`timescale 1ns/1ps
module tb_fsh_unit;

    localparam time PERIOD = 20ns;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] dst_i, src_i;
    logic [7:0]  cnt_i;
    logic        dir_right_i;
    logic [5:0]  flags_i;
    logic [15:0] result_o;
    logic [5:0]  flags_o;
    logic        wr_en_o;

    int checks = 0;
    int errors = 0;
    logic [31:0] lcg = 32'h1234_5678;
    bit done = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    fsh_unit dut (
        .clk         (clk),
        .rst         (rst),
        .dst_i       (dst_i),
        .src_i       (src_i),
        .cnt_i       (cnt_i),
        .dir_right_i (dir_right_i),
        .flags_i     (flags_i),
        .result_o    (result_o),
        .flags_o     (flags_o),
        .wr_en_o     (wr_en_o)
    );

    function automatic logic [31:0] next_rand(input logic [31:0] s);
        return s * 32'd1664525 + 32'd1013904223;
    endfunction

    // independent model: flags {OF,SF,ZF,AF,PF,CF}
    function automatic void model(input logic [15:0] d, input logic [15:0] s,
                                  input logic [7:0] cnt, input logic right,
                                  input logic [5:0] fin, output logic [15:0] r,
                                  output logic [5:0] f, output logic we);
        int c;
        int k;
        longint unsigned dd;
        longint unsigned ss;
        longint unsigned acc;
        logic cf;
        logic of;
        c  = int'(cnt) % 32;
        k  = c - 16;
        dd = longint'(d);
        ss = longint'(s);
        if (c == 0) begin
            r  = d;
            f  = fin;
            we = 1'b0;
            return;
        end
        if (!right) begin
            if (c <= 16) begin
                acc = (dd << c) | (ss >> (16 - c));
                cf  = dd[16 - c];
            end else begin
                acc = (ss << k) | (dd >> (16 - k));
                cf  = ss[32 - c];
            end
            r  = acc[15:0];
            of = cf ^ r[15];
        end else begin
            if (c <= 16) begin
                acc = (dd >> c) | (ss << (16 - c));
                cf  = dd[c - 1];
            end else begin
                acc = (ss >> k) | (dd << (16 - k));
                cf  = 1'b0;
            end
            r  = acc[15:0];
            of = r[15] ^ r[14];
        end
        f  = {of, r[15], (r == 16'h0), 1'b0, ~^r[7:0], cf};
        we = 1'b1;
    endfunction

    task automatic check16(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check6(input string tag, input logic [5:0] act, input logic [5:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic check1(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(PERIOD * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [15:0] er;
        logic [5:0]  ef;
        logic        ew;
        string       tag;
        rst         = 1'b1;
        dst_i       = 16'hA5A5;
        src_i       = 16'h5A5A;
        cnt_i       = 8'd3;
        dir_right_i = 1'b0;
        flags_i     = 6'h3F;
        repeat (3) @(negedge clk);
        // R8: reset clears the outputs
        check16("R8 reset result", result_o, 16'h0);
        check6("R8 reset flags", flags_o, 6'h0);
        check1("R8 reset wr_en", wr_en_o, 1'b0);
        rst = 1'b0;

        for (int dir = 0; dir < 2; dir++) begin
            for (int cnt = 0; cnt < 256; cnt++) begin
                for (int p = 0; p < 8; p++) begin
                    lcg = next_rand(lcg);
                    case (p)
                        0: begin dst_i = 16'h0000; src_i = 16'h0000; end
                        1: begin dst_i = 16'hFFFF; src_i = 16'hFFFF; end
                        2: begin dst_i = 16'h8000; src_i = 16'h0001; end
                        3: begin dst_i = 16'h0001; src_i = 16'h8000; end
                        default: begin
                            dst_i = lcg[31:16];
                            lcg   = next_rand(lcg);
                            src_i = lcg[31:16];
                        end
                    endcase
                    cnt_i       = 8'(cnt);
                    dir_right_i = dir[0];
                    flags_i     = lcg[13:8];
                    model(dst_i, src_i, cnt_i, dir_right_i, flags_i, er, ef, ew);
                    // result due one edge later (R8)
                    @(negedge clk);
                    if (cnt[4:0] == 5'd0) tag = "R7 zero count";
                    else if (cnt > 31)    tag = "R1 masked count";
                    else if (dir == 0)    tag = "R2 R4 left";
                    else                  tag = "R3 R5 right";
                    check16({tag, " result"}, result_o, er);
                    check6({tag, " flags R6"}, flags_o, ef);
                    check1({tag, " wr_en R7"}, wr_en_o, ew);
                end
            end
        end
        finish_run();
    end

endmodule